// File: doc/BRIEF.md
# Processor Bus Read-Cycle Controller

This block is the master-side sequencer for read transfers on a synchronous 32-bit processor bus. An internal requester hands it one request at a time through a ready/valid handshake. The request carries an address, a size code, two user attribute bits, a cacheable flag and a lock flag. The controller then runs the bus transfer. It drives the address, size, direction, attribute, cache-inhibit and lock lines. It pulses a one-clock start strobe, holds a busy (transfer-in-progress) line, and raises a one-clock status strobe once the access may be acknowledged. It captures the data on the acknowledging clock edge. Completion is reported with a one-clock response pulse and the captured data.

An optional wait interval delays the status strobe, and the acknowledge is not sampled during that interval. Its length comes from configuration inputs, and a length of zero means no wait. A line request is a 16-byte read. Normally it takes four back-to-back acknowledged beats. If the slave signals burst-inhibit on the first beat, the controller fetches the rest of the line with three single long-word transfers. These transfers step the address by 4 and wrap inside the line. The response presents the four words in line-address order.

Top module: `bus_read_ctrl`

## Requirements
- R1: During a transfer (busy high), the read/write line is high, the address holds steady except at a new start, `bus_attr` equals the request attribute, `bus_lock` equals the request lock flag, and `bus_cinh` is the inverse of the cacheable flag. In the start cycle of the first transfer, `bus_addr` equals the requested address.
- R2: `bus_size` uses these codes: long 2'b00, byte 2'b01, word 2'b10, line 2'b11. The first transfer of a request shows the requested code. Fallback transfers show long (2'b00).
- R3: `bus_start` is high for exactly one cycle at the beginning of every transfer. For the first transfer this is the cycle after the request is accepted. For a fallback transfer it is the cycle after the previous acknowledge.
- R4: `bus_busy` is high from the first start cycle until the final acknowledge. It stays high between fallback transfers and is low in the cycle after the final acknowledge.
- R5: `bus_status` is a one-cycle pulse per transfer. With `cfg_ign_en` low, or a count of zero, it is high in the cycle right after the start cycle. Otherwise it is high N+1 cycles after the start cycle, where N is `cfg_ign_cnt`.
- R6: `bus_ack` is ignored in the start cycle and during the wait interval. From the status cycle on, the data on `bus_rdata` is captured at the edge where `bus_ack` is sampled high.
- R7: For a byte, word or long request, `rsp_valid` pulses for one cycle, one cycle after the acknowledging edge. `rsp_line[31:0]` holds the captured data and the upper bits are zero.
- R8: For a line request without burst-inhibit on its first beat, four consecutive acknowledges are accepted and the address is held. Burst-inhibit on later beats is ignored. The beat with index k lands in `rsp_line` word ((addr[3:2]+k) mod 4), where word j occupies bits [32j+31:32j].
- R9: Burst-inhibit on the first beat of a line request causes three further long transfers. Each has its own start, wait interval and status strobe. Their addresses are {addr[31:4], (addr[3:2]+k) mod 4, 2'b00} for k=1..3, and the data lands in the same word slots as in R8.
- R10: `req_ready` is high only while no transfer is in progress. It drops in the cycle after acceptance and rises in the cycle `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_addr | input | 32 | Request byte address |
| req_size | input | 2 | Size code (long 00, byte 01, word 10, line 11) |
| req_attr | input | 2 | User attribute bits |
| req_cacheable | input | 1 | Access may be cached |
| req_lock | input | 1 | Hold bus lock for this request |
| cfg_ign_en | input | 1 | Enable the acknowledge wait interval |
| cfg_ign_cnt | input | 4 | Wait interval length in cycles |
| bus_addr | output | 32 | Bus address |
| bus_size | output | 2 | Bus size code |
| bus_rnw | output | 1 | Read/write line, high for read |
| bus_attr | output | 2 | Attribute lines |
| bus_cinh | output | 1 | Cache-inhibit out |
| bus_lock | output | 1 | Lock line |
| bus_start | output | 1 | One-clock transfer start strobe |
| bus_busy | output | 1 | Transfer in progress |
| bus_status | output | 1 | One-clock start-of-access status strobe |
| bus_ack | input | 1 | Transfer acknowledge from slave |
| bus_burst_inh | input | 1 | Burst inhibit from slave |
| bus_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_line | output | 128 | Captured data, word j at bits [32j+31:32j] |

## Verification
The bench steps one cycle at a time from the acceptance edge. It expects the start strobe in the next cycle and the status strobe 1+N cycles after that. Every fallback transfer begins one cycle after the previous acknowledge. The response and the drop of busy are expected exactly one cycle after the final acknowledging edge. The bench holds `bus_ack` high with junk data through the start and wait cycles, so any early sampling corrupts the expected data. Outputs are read at the falling edge in the cycle the count above predicts, and inputs change only at falling edges.

// File: rtl/bus_rd_pkg.sv
package bus_rd_pkg;

    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int ATTR_W         = 2;
    localparam int DEF_IGN_W      = 4;
    localparam int DEF_LINE_WORDS = 4;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_ACKW
    } rd_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        xfer_size_e        size;
        logic [ATTR_W-1:0] attr;
        logic              cacheable;
        logic              lock;
    } rd_req_t;

    function automatic logic is_line(input xfer_size_e s);
        return s == SZ_LINE;
    endfunction

endpackage

// File: rtl/rd_ign_timer.sv
module rd_ign_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/rd_line_buf.sv
module rd_line_buf #(
    parameter int DW    = 32,
    parameter int WORDS = 4,
    localparam int SW   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_slot,
    input  logic [DW-1:0]     wr_data,
    output logic [WORDS*DW-1:0] line
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                word_q <= '0;
            end else if (wr_en && wr_slot == SW'(w)) begin
                word_q <= wr_data;
            end
        end
        assign line[w*DW +: DW] = word_q;
    end
endmodule

// File: rtl/bus_read_ctrl.sv
module bus_read_ctrl
    import bus_rd_pkg::*;
#(
    parameter int IGN_W      = DEF_IGN_W,
    parameter int LINE_WORDS = DEF_LINE_WORDS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [1:0]                   req_size,
    input  logic [ATTR_W-1:0]            req_attr,
    input  logic                         req_cacheable,
    input  logic                         req_lock,
    input  logic                         cfg_ign_en,
    input  logic [IGN_W-1:0]             cfg_ign_cnt,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic [1:0]                   bus_size,
    output logic                         bus_rnw,
    output logic [ATTR_W-1:0]            bus_attr,
    output logic                         bus_cinh,
    output logic                         bus_lock,
    output logic                         bus_start,
    output logic                         bus_busy,
    output logic                         bus_status,
    input  logic                         bus_ack,
    input  logic                         bus_burst_inh,
    input  logic [DATA_W-1:0]            bus_rdata,
    output logic                         rsp_valid,
    output logic [LINE_WORDS*DATA_W-1:0] rsp_line
);
    localparam int SLOT_W    = $clog2(LINE_WORDS);
    localparam int OFS_W     = SLOT_W + 2;
    localparam logic [SLOT_W-1:0] LAST_BEAT = SLOT_W'(LINE_WORDS - 1);

    rd_state_e           state_q, state_d;
    rd_req_t             req_q, req_in;
    logic [SLOT_W-1:0]   slot_q;
    logic [SLOT_W-1:0]   beat_q;
    logic                fb_q;
    logic                stat_q;
    logic                rsp_q;

    logic                accept;
    logic                take_ack;
    logic                line_req;
    logic                wait_last;
    logic [IGN_W-1:0]    ign_val;
    logic                finish;
    logic                go_fallback;
    logic [SLOT_W-1:0]   wr_slot;

    assign req_in.addr      = req_addr;
    assign req_in.size      = xfer_size_e'(req_size);
    assign req_in.attr      = req_attr;
    assign req_in.cacheable = req_cacheable;
    assign req_in.lock      = req_lock;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign take_ack  = (state_q == ST_ACKW) && bus_ack;
    assign line_req  = is_line(req_q.size);
    assign ign_val   = cfg_ign_en ? cfg_ign_cnt : '0;

    assign go_fallback = take_ack && line_req && !fb_q && (beat_q == '0) && bus_burst_inh;
    assign finish      = take_ack && (!line_req || (beat_q == LAST_BEAT));
    assign wr_slot     = line_req ? slot_q : '0;

    rd_ign_timer #(.W(IGN_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_START),
        .load_val (ign_val),
        .last     (wait_last)
    );

    rd_line_buf #(.DW(DATA_W), .WORDS(LINE_WORDS)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .wr_en   (take_ack),
        .wr_slot (wr_slot),
        .wr_data (bus_rdata),
        .line    (rsp_line)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_START;
            ST_START: state_d = (ign_val == '0) ? ST_ACKW : ST_WAIT;
            ST_WAIT:  if (wait_last) state_d = ST_ACKW;
            ST_ACKW: begin
                if (finish)            state_d = ST_IDLE;
                else if (go_fallback)  state_d = ST_START;
                else if (take_ack && fb_q) state_d = ST_START;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            slot_q  <= '0;
            beat_q  <= '0;
            fb_q    <= 1'b0;
            stat_q  <= 1'b0;
            rsp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            stat_q  <= (state_d == ST_ACKW) && (state_q != ST_ACKW);
            rsp_q   <= finish;
            if (accept) begin
                req_q  <= req_in;
                slot_q <= req_addr[OFS_W-1:2];
                beat_q <= '0;
                fb_q   <= 1'b0;
            end else if (take_ack && !finish) begin
                slot_q <= slot_q + SLOT_W'(1);
                beat_q <= beat_q + SLOT_W'(1);
                if (go_fallback) fb_q <= 1'b1;
            end
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign bus_busy   = (state_q != ST_IDLE);
    assign bus_start  = (state_q == ST_START);
    assign bus_status = stat_q;
    assign rsp_valid  = rsp_q;
    assign bus_rnw    = 1'b1;
    assign bus_addr   = !bus_busy ? '0 :
                        fb_q ? {req_q.addr[ADDR_W-1:OFS_W], slot_q, 2'b00} : req_q.addr;
    assign bus_size   = (bus_busy && !fb_q) ? req_q.size : SZ_LONG;
    assign bus_attr   = bus_busy ? req_q.attr : '0;
    assign bus_cinh   = bus_busy && !req_q.cacheable;
    assign bus_lock   = bus_busy && req_q.lock;
endmodule

// File: rtl/bus_read_ctrl_chk.sv
module bus_read_ctrl_chk
    import bus_rd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_start,
    input logic              bus_busy,
    input logic              bus_status,
    input logic              bus_ack,
    input logic              rsp_valid
);
    // R3
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> !bus_start);

    // R3
    start_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> bus_busy);

    // R5
    status_placement_chk: assert property (@(posedge clk) disable iff (rst)
        bus_status |-> (bus_busy && !bus_start));

    // R5
    status_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        bus_status |=> !bus_status);

    // R10
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> !req_ready);

    // R7
    rsp_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!bus_busy && req_ready));

    // R4
    busy_end_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> rsp_valid);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !bus_start) |-> $stable(bus_addr));

    // R6
    early_ack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_start && bus_ack) |=> bus_busy);
endmodule

bind bus_read_ctrl bus_read_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .bus_addr   (bus_addr),
    .bus_start  (bus_start),
    .bus_busy   (bus_busy),
    .bus_status (bus_status),
    .bus_ack    (bus_ack),
    .rsp_valid  (rsp_valid)
);

// File: tb/tb_bus_read_ctrl.sv
module tb_bus_read_ctrl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic [1:0]   req_size;
    logic [1:0]   req_attr;
    logic         req_cacheable;
    logic         req_lock;
    logic         cfg_ign_en;
    logic [3:0]   cfg_ign_cnt;
    logic [31:0]  bus_addr;
    logic [1:0]   bus_size;
    logic         bus_rnw;
    logic [1:0]   bus_attr;
    logic         bus_cinh;
    logic         bus_lock;
    logic         bus_start;
    logic         bus_busy;
    logic         bus_status;
    logic         bus_ack;
    logic         bus_burst_inh;
    logic [31:0]  bus_rdata;
    logic         rsp_valid;
    logic [127:0] rsp_line;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_read_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_attr(req_attr),
        .req_cacheable(req_cacheable), .req_lock(req_lock),
        .cfg_ign_en(cfg_ign_en), .cfg_ign_cnt(cfg_ign_cnt),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_rnw(bus_rnw),
        .bus_attr(bus_attr), .bus_cinh(bus_cinh), .bus_lock(bus_lock),
        .bus_start(bus_start), .bus_busy(bus_busy), .bus_status(bus_status),
        .bus_ack(bus_ack), .bus_burst_inh(bus_burst_inh), .bus_rdata(bus_rdata),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] fb_addr(input logic [31:0] a, input int k);
        logic [1:0] s;
        s = a[3:2] + 2'(k);
        return {a[31:4], s, 2'b00};
    endfunction

    function automatic int slot_of(input logic [31:0] a, input int k);
        logic [1:0] s;
        s = a[3:2] + 2'(k);
        return int'(s);
    endfunction

    // Runs one transfer from its start cycle; leaves ack driven on the acknowledging cycle.
    task automatic run_beat(input logic [31:0] ea, input logic [1:0] es, input logic [1:0] attr,
                            input bit cache, input bit lock, input int n_ign, input int ack_wait,
                            input logic [31:0] d, input bit tbi);
        chk(bus_start == 1'b1, "R3 start strobe", 128'(bus_start), 128'(1));
        chk(bus_busy == 1'b1, "R4 busy at start", 128'(bus_busy), 128'(1));
        chk(bus_addr == ea, "R1 address", 128'(bus_addr), 128'(ea));
        chk(bus_size == es, "R2 size code", 128'(bus_size), 128'(es));
        chk(bus_rnw && bus_attr == attr && bus_cinh == !cache && bus_lock == lock,
            "R1 rnw/attr/cinh/lock", {bus_rnw, bus_attr, bus_cinh, bus_lock},
            {1'b1, attr, !cache, lock});
        chk(req_ready == 1'b0, "R10 ready low while busy", 128'(req_ready), 128'(0));
        bus_ack = 1'b1; bus_rdata = 32'hDEAD_0000 ^ $urandom; bus_burst_inh = 1'b0;
        for (int i = 0; i < n_ign; i++) begin
            @(negedge clk);
            chk(!bus_start && !bus_status && bus_busy, "R5 no status in wait",
                {bus_start, bus_status, bus_busy}, 128'(1));
            bus_rdata = 32'hBAD0_0000 ^ $urandom;
        end
        @(negedge clk);
        chk(bus_status == 1'b1, "R5 status strobe timing", 128'(bus_status), 128'(1));
        chk(bus_start == 1'b0, "R3 start one cycle", 128'(bus_start), 128'(0));
        for (int i = 0; i < ack_wait; i++) begin
            bus_ack = 1'b0;
            @(negedge clk);
            chk(bus_status == 1'b0 && bus_busy, "R5 status one cycle", {bus_status, bus_busy}, 128'(1));
        end
        bus_ack = 1'b1; bus_rdata = d; bus_burst_inh = tbi;
    endtask

    task automatic do_req(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] attr,
                          input bit cache, input bit lock, input bit en, input logic [3:0] cnt,
                          input bit tbi, input int ack_wait);
        int n;
        logic [31:0] d [4];
        logic [127:0] exp;
        n = en ? int'(cnt) : 0;
        for (int k = 0; k < 4; k++) d[k] = $urandom;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", 128'(req_ready), 128'(1));
        req_valid = 1'b1; req_addr = a; req_size = sz; req_attr = attr;
        req_cacheable = cache; req_lock = lock; cfg_ign_en = en; cfg_ign_cnt = cnt;
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_attr = ~attr; req_size = ~sz;
        req_cacheable = !cache; req_lock = !lock;
        exp = '0;
        if (sz != 2'b11) begin
            run_beat(a, sz, attr, cache, lock, n, ack_wait, d[0], tbi);
            exp[31:0] = d[0];
        end else if (!tbi) begin
            run_beat(a, 2'b11, attr, cache, lock, n, ack_wait, d[0], 1'b0);
            exp[slot_of(a, 0)*32 +: 32] = d[0];
            for (int k = 1; k < 4; k++) begin
                @(negedge clk);
                chk(bus_busy && !bus_start && !bus_status && bus_addr == a,
                    "R8 burst beat held", {bus_busy, bus_start, bus_status, bus_addr},
                    {3'b100, a});
                bus_ack = 1'b1; bus_rdata = d[k]; bus_burst_inh = 1'($urandom);
                exp[slot_of(a, k)*32 +: 32] = d[k];
            end
        end else begin
            run_beat(a, 2'b11, attr, cache, lock, n, ack_wait, d[0], 1'b1);
            exp[slot_of(a, 0)*32 +: 32] = d[0];
            for (int k = 1; k < 4; k++) begin
                @(negedge clk);
                // R9 fallback transfer k
                run_beat(fb_addr(a, k), 2'b00, attr, cache, lock, n, 0, d[k], 1'($urandom));
                exp[slot_of(a, k)*32 +: 32] = d[k];
            end
        end
        @(negedge clk);
        bus_ack = 1'b0; bus_burst_inh = 1'b0;
        chk(rsp_valid == 1'b1, "R7 response pulse", 128'(rsp_valid), 128'(1));
        chk(rsp_line == exp, sz == 2'b11 ? (tbi ? "R9 fallback line data" : "R8 burst line data")
                                         : "R6 captured data", rsp_line, exp);
        chk(!bus_busy && !bus_lock && req_ready, "R4 busy/lock drop, R10 ready",
            {bus_busy, bus_lock, req_ready}, 128'(1));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R7 response one cycle", 128'(rsp_valid), 128'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; req_attr = '0;
        req_cacheable = 1'b0; req_lock = 1'b0; cfg_ign_en = 1'b0; cfg_ign_cnt = '0;
        bus_ack = 1'b0; bus_burst_inh = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_busy && !bus_start && !bus_status && !rsp_valid && rsp_line == '0,
            "R10 reset state", {req_ready, bus_busy, bus_start, bus_status, rsp_valid}, 128'h10);

        // Directed corners
        do_req(32'h1000_0003, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 4'd5, 1'b0, 0); // R5 disabled count
        do_req(32'h2000_0002, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0, 2); // R5/R6 waits
        do_req(32'h3000_0004, 2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1, 0); // R5 zero count
        do_req(32'h4000_0008, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1); // R8 wrap
        do_req(32'h5000_000C, 2'b11, 2'b01, 1'b0, 1'b1, 1'b1, 4'd2, 1'b1, 0); // R9 wrap
        do_req(32'h6000_0000, 2'b11, 2'b10, 1'b1, 1'b0, 1'b1, 4'd15, 1'b1, 3); // R9 long wait

        for (int t = 0; t < 40; t++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            a  = $urandom;
            sz = 2'($urandom);
            if (sz == 2'b11 || sz == 2'b00) a[1:0] = 2'b00;
            do_req(a, sz, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                   4'($urandom_range(0, 6)), 1'($urandom), int'($urandom_range(0, 3)));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule